// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch Controller

This block drives one output clock from one of several free-running source clocks. It changes sources without producing a runt pulse. Software sets up a move through a small register port. It writes a source number together with a trigger bit. The controller then runs the move in hardware and reports progress and outcome in a status word. The output only ever runs from one lane at a time. Each lane is gated on a falling edge of its own clock. The enable for each lane crosses into that lane's clock domain through two flops before it acts.

A second request bit forces the output onto a fixed safe source, whatever the select field holds. Before hardware leaves the running source, it confirms that the clock it is about to rely on shows edges within a programmable number of register-clock cycles. If a commanded target stays silent, the move is abandoned and the output keeps its source. If the source being left by a forced safe move is silent, its gate is cleared asynchronously, because no falling edge will ever arrive to clear it. The status word records that case with its own code.

Top module: `clk_src_switch`

## Requirements
- R1: Writing address 0 with bit 8 (trigger) set starts a move to the source number in bits [SELW-1:0]. When the move completes, status bits [SELW-1:0] show that source and cause bits [12:10] read 1.
- R2: The trigger bit reads back as 1 in the cycle after the write. It clears itself on the following register-clock edge, when the controller takes the request.
- R3: Status bit 8 (busy) is set on the edge that takes the request. It stays set until the output runs from the new source.
- R4: Status bits [SELW-1:0] report the source actually driving the output. This is kept apart from the select field at address 0, and it changes only on the edge where busy falls.
- R5: The cause field at status bits [12:10] uses these codes: 0 after reset, 1 for a completed commanded move, 2 for a forced safe move, 3 for a forced safe move away from a silent source, and 4 for an abandoned move.
- R6: Writing bit 9 at address 0 forces the output onto source SAFE_IDX, whatever the select field holds, and sets the safe flag at status bit 13. A later completed commanded move clears the flag. If both request bits are written together, the safe request wins.
- R7: A trigger whose select equals the active source, while idle, starts nothing. Busy stays 0 and the status word is unchanged.
- R8: At most one lane gate is open at any time, and the output clock equals the active source's clock.
- R9: A trigger or safe request taken while busy is ignored. The move in flight completes to its original target, and no second move follows.
- R10: If the target of a commanded move shows no rising edge within the count held at address 1 bits [TMO_W-1:0], the move is abandoned. The active source is unchanged and the cause reads 4.
- R11: After reset the output runs from source SAFE_IDX, busy is 0, the cause reads 0 and the safe flag is 0.
- R12: A forced safe move away from a source that shows no edges within the timeout still completes onto SAFE_IDX, with cause 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and controller clock |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| src_clk | input | N_SRC | Candidate source clocks, one bit per lane |
| clk_out | output | 1 | Gated output clock |
| reg_wr | input | 1 | Write strobe, sampled on clk |
| reg_addr | input | 2 | Register address: 0 control, 1 timeout, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |

## Verification
Register effects are due one clk edge after a write: the trigger reads set right after the write edge, and busy is set with the trigger cleared after the next edge. The bench samples those reads at the falling clk edge that lies between the two. How long a move takes depends on the periods of the source clocks and on the synchronizer depth. Completion results are therefore not tied to one fixed cycle. The bench polls busy at each falling edge within a bounded window, then compares the full status word. The output clock is compared against the expected source at odd time points, which never fall on a source edge, so no comparison races a clock transition.

// File: rtl/csw_pkg.sv
package csw_pkg;
  typedef enum logic [2:0] {
    CZ_RESET     = 3'd0,
    CZ_OK        = 3'd1,
    CZ_SAFE      = 3'd2,
    CZ_SAFE_DEAD = 3'd3,
    CZ_FAIL      = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROBE,
    ST_STOP,
    ST_START
  } sw_state_e;

  localparam int          REG_DW  = 32;
  localparam logic [1:0]  A_CTRL  = 2'd0;
  localparam logic [1:0]  A_TMO   = 2'd1;
  localparam logic [1:0]  A_STAT  = 2'd2;
  localparam int          B_TRIG  = 8;
  localparam int          B_SAFE  = 9;
  localparam int          B_BUSY  = 8;
  localparam int          B_CAUSE = 10;
  localparam int          B_SMODE = 13;
endpackage

// File: rtl/csw_lane.sv
module csw_lane #(
  parameter bit ON_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_clk,
  input  logic req,
  input  logic kill,
  output logic gclk,
  output logic gate,
  output logic on,
  output logic alive
);
  logic rq_s1, rq_s2;
  logic on_s1, on_s2;
  logic tog;
  logic act_s1, act_s2, act_s3;

  // enable request crosses into the source domain
  always_ff @(posedge src_clk or negedge rst_n or posedge kill) begin
    if (!rst_n) begin
      rq_s1 <= ON_AT_RESET;
      rq_s2 <= ON_AT_RESET;
    end else if (kill) begin
      rq_s1 <= 1'b0;
      rq_s2 <= 1'b0;
    end else begin
      rq_s1 <= req;
      rq_s2 <= rq_s1;
    end
  end

  // gate changes only while the source is low
  always_ff @(negedge src_clk or negedge rst_n or posedge kill) begin
    if (!rst_n)    gate <= ON_AT_RESET;
    else if (kill) gate <= 1'b0;
    else           gate <= rq_s2;
  end

  assign gclk = src_clk & gate;

  // gate state returned to the controller domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_s1 <= ON_AT_RESET;
      on_s2 <= ON_AT_RESET;
    end else begin
      on_s1 <= gate;
      on_s2 <= on_s1;
    end
  end
  assign on = on_s2;

  // activity detector: toggle in source domain, edge detect in clk domain
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_s1 <= 1'b0;
      act_s2 <= 1'b0;
      act_s3 <= 1'b0;
    end else begin
      act_s1 <= tog;
      act_s2 <= act_s1;
      act_s3 <= act_s2;
    end
  end
  assign alive = act_s2 ^ act_s3;
endmodule

// File: rtl/csw_regs.sv
module csw_regs
  import csw_pkg::*;
#(
  parameter int SELW    = 2,
  parameter int TMO_W   = 16,
  parameter int TMO_DEF = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              take,
  input  logic [SELW-1:0]   cur,
  input  logic              busy,
  input  cause_e            cause,
  input  logic              smode,
  output logic [SELW-1:0]   sel,
  output logic              trig,
  output logic              sreq,
  output logic [TMO_W-1:0]  tmo,
  output logic [REG_DW-1:0] rdata
);
  logic ctrl_wr, tmo_wr;
  assign ctrl_wr = wr && (addr == A_CTRL);
  assign tmo_wr  = wr && (addr == A_TMO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= '0;
      trig <= 1'b0;
      sreq <= 1'b0;
      tmo  <= TMO_W'(TMO_DEF);
    end else begin
      if (ctrl_wr) begin
        sel  <= wdata[SELW-1:0];
        trig <= wdata[B_TRIG];
        sreq <= wdata[B_SAFE];
      end else if (take) begin
        trig <= 1'b0;
        sreq <= 1'b0;
      end
      if (tmo_wr) tmo <= wdata[TMO_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[SELW-1:0] = sel;
        rdata[B_TRIG]   = trig;
        rdata[B_SAFE]   = sreq;
      end
      A_TMO: rdata[TMO_W-1:0] = tmo;
      A_STAT: begin
        rdata[SELW-1:0]      = cur;
        rdata[B_BUSY]        = busy;
        rdata[B_CAUSE +: 3]  = cause;
        rdata[B_SMODE]       = smode;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/csw_ctrl.sv
module csw_ctrl
  import csw_pkg::*;
#(
  parameter int N_SRC    = 4,
  parameter int SELW     = 2,
  parameter int TMO_W    = 16,
  parameter int SAFE_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             sreq,
  input  logic [SELW-1:0]  sel,
  input  logic [TMO_W-1:0] tmo,
  input  logic [N_SRC-1:0] alive,
  input  logic [N_SRC-1:0] on,
  output logic             take,
  output logic [N_SRC-1:0] req,
  output logic [N_SRC-1:0] kill,
  output logic [SELW-1:0]  cur,
  output logic             busy,
  output cause_e           cause,
  output logic             smode
);
  localparam logic [SELW-1:0] SAFE_SEL = SELW'(SAFE_IDX);

  sw_state_e       st;
  logic [SELW-1:0] tgt;
  logic            op_safe;
  logic            old_dead;
  logic [TMO_W-1:0] tmr;
  logic [SELW-1:0] probe;
  logic            sel_ok;

  assign take   = trig | sreq;
  assign probe  = op_safe ? cur : tgt;
  assign sel_ok = ({1'b0, sel} < (SELW+1)'(N_SRC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur      <= SAFE_SEL;
      tgt      <= SAFE_SEL;
      op_safe  <= 1'b0;
      old_dead <= 1'b0;
      tmr      <= '0;
      req      <= N_SRC'(1) << SAFE_IDX;
      kill     <= '0;
      busy     <= 1'b0;
      cause    <= CZ_RESET;
      smode    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (sreq) begin
            if (cur == SAFE_SEL) begin
              cause <= CZ_SAFE;
              smode <= 1'b1;
            end else begin
              tgt      <= SAFE_SEL;
              op_safe  <= 1'b1;
              old_dead <= 1'b0;
              busy     <= 1'b1;
              tmr      <= '0;
              st       <= ST_PROBE;
            end
          end else if (trig && sel_ok && (sel != cur)) begin
            tgt      <= sel;
            op_safe  <= 1'b0;
            old_dead <= 1'b0;
            busy     <= 1'b1;
            tmr      <= '0;
            st       <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (alive[probe]) begin
            req[cur] <= 1'b0;
            st       <= ST_STOP;
          end else if (tmr >= tmo) begin
            if (op_safe) begin
              old_dead  <= 1'b1;
              req[cur]  <= 1'b0;
              kill[cur] <= 1'b1;
              st        <= ST_STOP;
            end else begin
              cause <= CZ_FAIL;
              busy  <= 1'b0;
              st    <= ST_IDLE;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_STOP: begin
          if (!on[cur]) begin
            kill[tgt] <= 1'b0;
            req[tgt]  <= 1'b1;
            st        <= ST_START;
          end
        end
        ST_START: begin
          if (on[tgt]) begin
            cur   <= tgt;
            busy  <= 1'b0;
            smode <= op_safe;
            if (!op_safe)      cause <= CZ_OK;
            else if (old_dead) cause <= CZ_SAFE_DEAD;
            else               cause <= CZ_SAFE;
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import csw_pkg::*;
#(
  parameter int N_SRC       = 4,
  parameter int SAFE_IDX    = 0,
  parameter int TMO_W       = 16,
  parameter int TMO_DEFAULT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_clk,
  output logic             clk_out,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata
);
  localparam int SELW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [SELW-1:0]  sel;
  logic             trig, sreq, take;
  logic [TMO_W-1:0] tmo;
  logic [N_SRC-1:0] req_v, kill_v, on_v, alive_v, gate_v, gclk_v;
  logic [SELW-1:0]  cur;
  logic             busy, smode;
  cause_e           cause;

  csw_regs #(.SELW(SELW), .TMO_W(TMO_W), .TMO_DEF(TMO_DEFAULT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .take(take), .cur(cur), .busy(busy), .cause(cause), .smode(smode),
    .sel(sel), .trig(trig), .sreq(sreq), .tmo(tmo), .rdata(reg_rdata)
  );

  csw_ctrl #(.N_SRC(N_SRC), .SELW(SELW), .TMO_W(TMO_W), .SAFE_IDX(SAFE_IDX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .sreq(sreq), .sel(sel), .tmo(tmo),
    .alive(alive_v), .on(on_v), .take(take), .req(req_v), .kill(kill_v),
    .cur(cur), .busy(busy), .cause(cause), .smode(smode)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_lane
    csw_lane #(.ON_AT_RESET(g == SAFE_IDX)) u_lane (
      .clk(clk), .rst_n(rst_n), .src_clk(src_clk[g]), .req(req_v[g]),
      .kill(kill_v[g]), .gclk(gclk_v[g]), .gate(gate_v[g]),
      .on(on_v[g]), .alive(alive_v[g])
    );
  end

  assign clk_out = |gclk_v;
endmodule

// File: rtl/csw_checker.sv
module csw_checker
  import csw_pkg::*;
#(
  parameter int N_SRC    = 4,
  parameter int SELW     = 2,
  parameter int SAFE_IDX = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr_trig,
  input logic             trig,
  input logic             take,
  input logic             busy,
  input logic [SELW-1:0]  cur,
  input cause_e           cause,
  input logic             smode,
  input logic [N_SRC-1:0] gate_v
);
  // R2: trigger self-clears unless rewritten
  assert_trig_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !ctrl_wr_trig) |=> !trig);

  // R3: busy only rises on a taken request
  assert_busy_from_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(take));

  // R4: active source only changes as busy falls
  assert_cur_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> $fell(busy));

  // R6: safe flag implies safe source
  assert_safe_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smode |-> (cur == SELW'(SAFE_IDX)));

  // R8: never two open gates
  assert_one_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_v));

  // R10: a failure leaves the active source alone
  assert_fail_keeps_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cause) && (cause == CZ_FAIL)) |-> $stable(cur));

  // R11: reset state
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R11: assert ((cur == SELW'(SAFE_IDX)) && !busy &&
                                      (cause == CZ_RESET) && !smode)
        else $error("reset state wrong");
    end
  end
endmodule

bind clk_src_switch csw_checker #(.N_SRC(N_SRC), .SELW(SELW), .SAFE_IDX(SAFE_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ctrl_wr_trig(reg_wr && (reg_addr == 2'd0) && reg_wdata[8]),
  .trig(trig), .take(take), .busy(busy), .cur(cur), .cause(cause),
  .smode(smode), .gate_v(gate_v)
);

// File: tb/clk_src_switch_tb.sv
module clk_src_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int SRC_HALF [NS] = '{14, 22, 30, 46};

  logic        clk;
  logic        rst_n;
  wire  [NS-1:0] src_clk;
  logic [NS-1:0] run;
  logic        clk_out;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  clk_src_switch #(.N_SRC(NS), .SAFE_IDX(0), .TMO_W(16), .TMO_DEFAULT(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .clk_out(clk_out),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  for (genvar g = 0; g < NS; g++) begin : g_src
    logic sc;
    initial begin
      sc = 1'b0;
      forever begin
        #(SRC_HALF[g]);
        if (run[g]) sc = ~sc;
        else        sc = 1'b0;
      end
    end
    assign src_clk[g] = sc;
  end

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      begin
        item_t it;
        it = sb_q[0];
        checks++;
        if ((reg_rdata & it.mask) !== it.exp) begin
          errors++;
          $display("FAIL %s got %h exp %h", it.tag, reg_rdata & it.mask, it.exp);
        end
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic expect_rd(input logic [1:0] a, input logic [31:0] m,
                           input logic [31:0] e, input string tag);
    item_t it;
    reg_addr = a;
    #1;
    it.mask = m; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(input string tag);
    bit done;
    done = 1'b0;
    cycles(2);
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      reg_addr = 2'd2;
      #1;
      if (!reg_rdata[8]) begin
        done = 1'b1;
        break;
      end
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL %s busy never dropped got 1 exp 0", tag);
    end
  endtask

  task automatic follow(input int s, input string tag);
    int bad;
    bad = 0;
    if (($time % 2) == 0) #1;
    repeat (150) begin
      if (clk_out !== src_clk[s]) bad++;
      #2;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s clk_out mismatches got %0d exp 0", tag, bad);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired got running exp finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0; run = '1;
    cycles(5);
    rst_n = 1'b1;
    cycles(20);

    // R11: reset state and output on safe source
    expect_rd(2'd2, 32'h3FFF, 32'h0, "R11 status after reset");
    follow(0, "R11/R8 output on safe source after reset");

    // R10: timeout register programmable
    wr_reg(2'd1, 32'd40);
    expect_rd(2'd1, 32'hFFFF, 32'd40, "R10 timeout readback");

    // R1/R2/R3/R4: commanded move to source 2
    wr_reg(2'd0, 32'h102);
    expect_rd(2'd0, 32'h100, 32'h100, "R2 trigger reads set");
    @(negedge clk);
    expect_rd(2'd0, 32'h100, 32'h0, "R2 trigger self-cleared");
    expect_rd(2'd2, 32'h1FF, 32'h100, "R3 busy set, R4 source still 0");
    wait_idle("R1 move to 2");
    expect_rd(2'd2, 32'h3FFF, 32'h402, "R1/R5 on source 2 cause 1");
    follow(2, "R8 output follows source 2");

    // R9: request while busy ignored
    wr_reg(2'd0, 32'h103);
    @(negedge clk);
    expect_rd(2'd2, 32'h100, 32'h100, "R9 first move busy");
    wr_reg(2'd0, 32'h101);
    wait_idle("R9 move to 3");
    expect_rd(2'd2, 32'h3FFF, 32'h403, "R9 completed to original target 3");
    cycles(10);
    expect_rd(2'd2, 32'h3FFF, 32'h403, "R9 no second move");
    follow(3, "R8 output follows source 3");

    // R7: select already active
    wr_reg(2'd0, 32'h103);
    cycles(2);
    expect_rd(2'd2, 32'h3FFF, 32'h403, "R7 no move when already active");

    // R10: dead target abandoned
    run[1] = 1'b0;
    cycles(10);
    wr_reg(2'd0, 32'h101);
    cycles(20);
    expect_rd(2'd2, 32'h100, 32'h100, "R10 still waiting before timeout");
    wait_idle("R10 dead target");
    expect_rd(2'd2, 32'h3FFF, 32'h1003, "R10/R5 cause 4, source stays 3");
    follow(3, "R10 output still on source 3");

    // R6: forced safe move overrides select
    wr_reg(2'd0, 32'h201);
    wait_idle("R6 safe move");
    expect_rd(2'd2, 32'h3FFF, 32'h2800, "R6/R5 safe source, cause 2, flag set");
    expect_rd(2'd0, 32'hFF, 32'h1, "R4 select field kept separate");
    follow(0, "R6 output on safe source");

    // R6: commanded move clears safe flag
    wr_reg(2'd0, 32'h102);
    wait_idle("R6 leave safe");
    expect_rd(2'd2, 32'h3FFF, 32'h402, "R6 flag cleared after commanded move");

    // R6: safe request wins over a simultaneous trigger
    wr_reg(2'd0, 32'h303);
    wait_idle("R6 both bits");
    expect_rd(2'd2, 32'h3FFF, 32'h2800, "R6 safe wins over trigger");

    // R12: forced safe move away from a silent source
    wr_reg(2'd0, 32'h102);
    wait_idle("R12 setup");
    run[2] = 1'b0;
    cycles(10);
    wr_reg(2'd0, 32'h200);
    wait_idle("R12 safe from dead");
    expect_rd(2'd2, 32'h3FFF, 32'h2C00, "R12/R5 cause 3 on safe source");
    follow(0, "R12 output on safe source");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule